// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block takes stereo audio arriving on a three-wire serial link (bit clock, word-select clock and serial data) and turns it into a parallel pair of 20-bit two's-complement samples, one for the left channel and one for the right channel, with a single-cycle valid strobe. All logic runs on the master clock. The three link inputs are synchronised into that domain, and their edges are found by comparing registered samples.

A 2-bit format input selects one of four framings. The framings differ in word length, in whether the word is packed against the start or the end of each word-select phase, in which bit-clock edge captures data, and in the word-select polarity. The bit clock either comes from the pin or is generated inside the block. The internal clock is locked to the master clock at 64 bit periods per word-select period. Out of reset the block uses its internal clock. It switches to the pin for good once enough bit-clock activity is seen within one word-select phase. Only a reset takes it back to internal mode.

Top module: `stereo_serial_rx`

## Requirements
- R1: Format code 2'b00 takes the last 16 bits of each word-select phase, MSB first, captured on rising bit-clock edges. The word is sign-extended to 20 bits, and earlier bits in the phase are ignored.
- R2: Format code 2'b01 takes the last 20 bits of each phase, MSB first, captured on rising bit-clock edges, and ignores earlier bits.
- R3: Format code 2'b10 takes the first 20 bits of each phase, MSB first, captured on falling bit-clock edges, and ignores later bits. A 16-bit word followed by four zero bits arrives as that word shifted left by 4.
- R4: Format code 2'b11 ignores the first bit of each phase and takes the next 20 bits, MSB first, on rising bit-clock edges. Later bits are ignored, and a 16-bit word padded with zeros arrives shifted left by 4.
- R5: Word-select high marks the left channel for codes 2'b00 to 2'b10, and low marks it for 2'b11. After each right-channel word closes on a word-select edge, `pair_valid` pulses for exactly one cycle. The outputs then hold the left word that came just before and that right word, and they stay unchanged until the next pulse.
- R6: The block enters external bit-clock mode (`ext_clk_mode`=1) once 15 transitions of the bit-clock pin are seen within one word-select phase. Phases that each have 14 or fewer transitions never set it.
- R7: External mode stays set until reset, even when the bit-clock pin stops.
- R8: In internal mode, with the bit-clock pin held low, each word-select phase of MCLK_PER_WS/2 master cycles carries 32 bits. Bit k is sampled at the middle of master cycles [k*MCLK_PER_WS/64, (k+1)*MCLK_PER_WS/64) counted from the word-select change.
- R9: After reset, both sample outputs are 0, `pair_valid` is 0 and `ext_clk_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset (power-down) |
| sclk_pin | input | 1 | Serial bit clock from the pin; tie low for internal mode |
| ws_pin | input | 1 | Word-select (channel) clock |
| sd_pin | input | 1 | Serial data, MSB first |
| fmt_sel | input | 2 | Framing format code |
| left_out | output | 20 | Left-channel sample |
| right_out | output | 20 | Right-channel sample |
| pair_valid | output | 1 | One-cycle strobe when a new pair is on the outputs |
| ext_clk_mode | output | 1 | 1 when the pin bit clock is in use |

## Verification
Every format runs under both bit-clock sources. Each run uses a set of words chosen to separate the cases: full-scale negative and positive, the value one, all ones, a walking single bit, and mixed values derived arithmetically. Unused bit slots carry alternating ones and zeros, so capture from the wrong window or the wrong edge shows up as a corrupted word, and a missing sign extension shows up on negative 16-bit words. Padded 16-bit words in the two front-aligned formats check the shift-by-four result. Separate phases with 14 and with 15 bit-clock transitions locate the mode-switch threshold exactly, and a stopped pin clock followed by a reset shows that the mode is sticky and is cleared only by reset.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int SAMPLE_W = 20;
    localparam int SHORT_W  = 16;

    typedef enum logic [1:0] {
        FMT_RJ16  = 2'b00,
        FMT_RJ20  = 2'b01,
        FMT_LJ20  = 2'b10,
        FMT_I2S20 = 2'b11
    } frame_fmt_e;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        logic sclk;
        logic ws;
        logic sd;
    } link_bits_t;

    typedef struct packed {
        logic bit_ev;
        logic ws_ev;
        logic ws_now;
        logic sd;
    } capture_ctl_t;

    // Turn the two capture windows into the final word for a format.
    function automatic sample_t finish_word(frame_fmt_e f, sample_t tail, sample_t head);
        sample_t w;
        case (f)
            FMT_RJ16: w = {{(SAMPLE_W-SHORT_W){tail[SHORT_W-1]}}, tail[SHORT_W-1:0]};
            FMT_RJ20: w = tail;
            default:  w = head;
        endcase
        return w;
    endfunction

    // Decide if the phase that just closed carried the left channel.
    function automatic logic phase_was_left(frame_fmt_e f, logic ws_before);
        return (f == FMT_I2S20) ? !ws_before : ws_before;
    endfunction

    function automatic logic latch_on_fall(frame_fmt_e f);
        return f == FMT_LJ20;
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_bclk.sv
module srx_bclk
    import srx_pkg::*;
#(
    parameter int MCLK_PER_WS = 256,
    parameter int EXT_EDGES   = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  frame_fmt_e fmt,
    input  logic       sclk_s,
    input  logic       ws_s,
    output logic       bit_ev,
    output logic       ws_ev,
    output logic       ext_mode
);
    localparam int DIV   = MCLK_PER_WS / 64;
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int TC_W  = $clog2(EXT_EDGES + 1);
    localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(DIV - 1);
    localparam logic [CNT_W-1:0] DIV_MID  = CNT_W'(DIV / 2);
    localparam logic [TC_W-1:0]  TC_MAX   = TC_W'(EXT_EDGES);
    localparam logic [TC_W-1:0]  TC_ARM   = TC_W'(EXT_EDGES - 1);

    logic             sclk_q, ws_q, ext_q;
    logic [CNT_W-1:0] div_q, div_now;
    logic [TC_W-1:0]  tcnt_q;
    logic             sclk_rise, sclk_fall, sclk_edge, int_ev, pin_ev;

    assign ws_ev     = ws_s ^ ws_q;
    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign sclk_edge = sclk_rise | sclk_fall;

    // Internal bit clock: restarts on each word-select edge, samples mid-bit.
    assign div_now = ws_ev ? '0 : div_q;
    assign int_ev  = (div_now == DIV_MID);
    assign pin_ev  = latch_on_fall(fmt) ? sclk_fall : sclk_rise;
    assign bit_ev  = ext_q ? pin_ev : int_ev;
    assign ext_mode = ext_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            ws_q   <= 1'b0;
            div_q  <= '0;
            tcnt_q <= '0;
            ext_q  <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            ws_q   <= ws_s;
            div_q  <= (div_now == DIV_LAST) ? '0 : div_now + 1'b1;
            if (ws_ev)
                tcnt_q <= {{(TC_W-1){1'b0}}, sclk_edge};
            else if (sclk_edge && tcnt_q != TC_MAX)
                tcnt_q <= tcnt_q + 1'b1;
            if (sclk_edge && !ws_ev && tcnt_q == TC_ARM)
                ext_q <= 1'b1;
        end
    end

    assert_ext_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ext_q |=> ext_q);

    assert_ext_threshold_R6: assert property (@(posedge clk) disable iff (rst)
        (!ext_q && tcnt_q < TC_ARM) |=> !ext_q);
endmodule

// File: rtl/srx_capture.sv
module srx_capture
    import srx_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  frame_fmt_e   fmt,
    input  capture_ctl_t ctl,
    output sample_t      left_q,
    output sample_t      right_q,
    output logic         valid_q
);
    localparam int NB_W = 6;
    localparam logic [NB_W-1:0] NB_MAX = '1;
    localparam logic [NB_W-1:0] NB_LEN = NB_W'(SAMPLE_W);

    sample_t         tail_q, head_q, left_hold_q, word;
    logic [NB_W-1:0] nb_q;
    logic            in_head, closed_left;

    always_comb begin
        case (fmt)
            FMT_LJ20:  in_head = nb_q < NB_LEN;
            FMT_I2S20: in_head = (nb_q != '0) && (nb_q <= NB_LEN);
            default:   in_head = 1'b0;
        endcase
    end

    assign word        = finish_word(fmt, tail_q, head_q);
    assign closed_left = phase_was_left(fmt, ~ctl.ws_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_q      <= '0;
            head_q      <= '0;
            left_hold_q <= '0;
            left_q      <= '0;
            right_q     <= '0;
            valid_q     <= 1'b0;
            nb_q        <= '0;
        end else begin
            valid_q <= 1'b0;
            if (ctl.ws_ev) begin
                if (closed_left) begin
                    left_hold_q <= word;
                end else begin
                    left_q  <= left_hold_q;
                    right_q <= word;
                    valid_q <= 1'b1;
                end
                head_q <= '0;
                nb_q   <= '0;
            end else if (ctl.bit_ev) begin
                tail_q <= {tail_q[SAMPLE_W-2:0], ctl.sd};
                if (in_head) head_q <= {head_q[SAMPLE_W-2:0], ctl.sd};
                if (nb_q != NB_MAX) nb_q <= nb_q + 1'b1;
            end
        end
    end

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    assert_valid_after_ws_R5: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(ctl.ws_ev));

    assert_hold_outputs_R5: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> ($stable(left_q) && $stable(right_q)));
endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
    import srx_pkg::*;
#(
    parameter int MCLK_PER_WS = 256,
    parameter int EXT_EDGES   = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sclk_pin,
    input  logic        ws_pin,
    input  logic        sd_pin,
    input  logic [1:0]  fmt_sel,
    output logic [19:0] left_out,
    output logic [19:0] right_out,
    output logic        pair_valid,
    output logic        ext_clk_mode
);
    frame_fmt_e   fmt;
    link_bits_t   raw, synced;
    capture_ctl_t ctl;
    logic         bit_ev, ws_ev;
    sample_t      left_w, right_w;

    assign fmt = frame_fmt_e'(fmt_sel);
    assign raw = '{sclk: sclk_pin, ws: ws_pin, sd: sd_pin};

    srx_sync #(.W($bits(link_bits_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    srx_bclk #(.MCLK_PER_WS(MCLK_PER_WS), .EXT_EDGES(EXT_EDGES)) u_bclk (
        .clk      (clk),
        .rst      (rst),
        .fmt      (fmt),
        .sclk_s   (synced.sclk),
        .ws_s     (synced.ws),
        .bit_ev   (bit_ev),
        .ws_ev    (ws_ev),
        .ext_mode (ext_clk_mode)
    );

    assign ctl = '{bit_ev: bit_ev, ws_ev: ws_ev, ws_now: synced.ws, sd: synced.sd};

    srx_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .fmt     (fmt),
        .ctl     (ctl),
        .left_q  (left_w),
        .right_q (right_w),
        .valid_q (pair_valid)
    );

    assign left_out  = left_w;
    assign right_out = right_w;
endmodule

// File: tb/stereo_serial_rx_tb.sv
module stereo_serial_rx_tb;
    localparam int MPW  = 256;
    localparam int DIV  = MPW / 64;
    localparam int NFR  = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk_pin = 1'b0, ws_pin = 1'b0, sd_pin = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic [19:0] left_out, right_out;
    logic        pair_valid, ext_clk_mode;

    int n_chk = 0, n_fail = 0, nrx = 0;
    logic dbl = 1'b0, prev_v = 1'b0;
    logic [19:0] rx_l [0:255];
    logic [19:0] rx_r [0:255];
    logic [19:0] exp_l [0:NFR-1];
    logic [19:0] exp_r [0:NFR-1];

    stereo_serial_rx #(.MCLK_PER_WS(MPW)) u_dut (
        .clk(clk), .rst(rst), .sclk_pin(sclk_pin), .ws_pin(ws_pin), .sd_pin(sd_pin),
        .fmt_sel(fmt_sel), .left_out(left_out), .right_out(right_out),
        .pair_valid(pair_valid), .ext_clk_mode(ext_clk_mode)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (!rst && pair_valid) begin
            if (nrx < 256) begin
                rx_l[nrx] = left_out;
                rx_r[nrx] = right_out;
            end
            nrx++;
            if (prev_v) dbl = 1'b1;
        end
        prev_v = pair_valid;
    end

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired (R5): got hang, expected completion");
        n_chk++; n_fail++;
        summary();
        $finish;
    end

    task automatic chk(string req, logic [31:0] got, logic [31:0] expv);
        n_chk++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, expv);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [19:0] pat(int j, int salt);
        case (j)
            0: return 20'h80000;
            1: return 20'h7FFFF;
            2: return 20'h00001;
            3: return 20'hFFFFF;
            4: return 20'h00001 << (salt % 20);
            default: return 20'(j * 32'h2B5C7 + salt * 32'h1F3 + 32'h9D);
        endcase
    endfunction

    // Bit carried in slot k of a phase; unused slots alternate.
    function automatic logic bitval(int f, logic [19:0] w, int k);
        case (f)
            0: return (k >= 16) ? w[31-k] : k[0];
            1: return (k >= 12) ? w[31-k] : k[0];
            2: return (k < 20) ? w[19-k] : k[0];
            default: return (k >= 1 && k <= 20) ? w[20-k] : k[0];
        endcase
    endfunction

    task automatic drive_phase(int f, bit ext, logic wl, logic [19:0] w);
        for (int k = 0; k < 32; k++) begin
            ws_pin = wl;
            sd_pin = bitval(f, w, k);
            if (!ext) begin
                sclk_pin = 1'b0;
                tick(DIV);
            end else begin
                sclk_pin = (f == 2);
                tick(2);
                sclk_pin = (f != 2);
                tick(2);
            end
        end
    endtask

    task automatic run(int f, bit ext, bit pad16, int salt, string req);
        logic lft;
        int base;
        logic [19:0] sl, sr, l, r;
        fmt_sel = 2'(f);
        lft = (f == 3) ? 1'b0 : 1'b1;
        base = nrx;
        drive_phase(f, ext, ~lft, 20'h0);
        for (int j = 0; j < NFR; j++) begin
            l = pat(j, salt);
            r = pat(j, salt + 7) ^ 20'h5A5A5;
            case (f)
                0: begin
                    sl = {4'h0, l[15:0]}; sr = {4'h0, r[15:0]};
                    exp_l[j] = {{4{l[15]}}, l[15:0]}; exp_r[j] = {{4{r[15]}}, r[15:0]};
                end
                1: begin sl = l; sr = r; exp_l[j] = l; exp_r[j] = r; end
                default: begin
                    sl = pad16 ? {l[15:0], 4'h0} : l;
                    sr = pad16 ? {r[15:0], 4'h0} : r;
                    exp_l[j] = sl; exp_r[j] = sr;
                end
            endcase
            drive_phase(f, ext, lft, sl);
            drive_phase(f, ext, ~lft, sr);
        end
        drive_phase(f, ext, lft, 20'h0);
        chk({req, " R5 pair count"}, 32'(nrx), 32'(base + 1 + NFR));
        for (int j = 0; j < NFR; j++) begin
            if (base + 1 + j < 256) begin
                chk({req, " left"},  32'(rx_l[base + 1 + j]), 32'(exp_l[j]));
                chk({req, " right"}, 32'(rx_r[base + 1 + j]), 32'(exp_r[j]));
            end
        end
        chk({req, " R5 hold left"},  32'(left_out),  32'(exp_l[NFR-1]));
        chk({req, " R5 hold right"}, 32'(right_out), 32'(exp_r[NFR-1]));
    endtask

    task automatic toggle_phase(logic wl, int ntog);
        ws_pin = wl;
        tick(2);
        for (int i = 0; i < ntog; i++) begin
            sclk_pin = ~sclk_pin;
            tick(4);
        end
        tick(MPW / 2 - 2 - 4 * ntog);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        chk("R9 left", 32'(left_out), 32'h0);
        chk("R9 right", 32'(right_out), 32'h0);
        chk("R9 valid", 32'(pair_valid), 32'h0);
        chk("R9 ext", 32'(ext_clk_mode), 32'h0);

        // Internal bit clock, all four formats
        run(0, 1'b0, 1'b0, 0, "R1/R8 internal");
        run(1, 1'b0, 1'b0, 1, "R2/R8 internal");
        run(2, 1'b0, 1'b0, 2, "R3/R8 internal");
        run(3, 1'b0, 1'b0, 3, "R4/R8 internal");
        chk("R8 still internal", 32'(ext_clk_mode), 32'h0);

        // Threshold: 14 per phase must not switch, 15 must
        fmt_sel = 2'b01;
        toggle_phase(1'b1, 14);
        toggle_phase(1'b0, 14);
        toggle_phase(1'b1, 14);
        chk("R6 14 transitions", 32'(ext_clk_mode), 32'h0);
        toggle_phase(1'b0, 15);
        chk("R6 15 transitions", 32'(ext_clk_mode), 32'h1);

        // Pin bit clock, all four formats plus padded short words
        run(0, 1'b1, 1'b0, 10, "R1 external");
        run(1, 1'b1, 1'b0, 11, "R2 external");
        run(2, 1'b1, 1'b0, 12, "R3 external");
        run(3, 1'b1, 1'b0, 13, "R4 external");
        run(2, 1'b1, 1'b1, 14, "R3 padded16");
        run(3, 1'b1, 1'b1, 15, "R4 padded16");

        // Stop the pin clock: mode must stay
        sclk_pin = 1'b0;
        for (int p = 0; p < 4; p++) begin
            ws_pin = ~ws_pin;
            tick(MPW / 2);
        end
        chk("R7 sticky", 32'(ext_clk_mode), 32'h1);

        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(2);
        chk("R7 reset clears", 32'(ext_clk_mode), 32'h0);
        chk("R9 valid after reset", 32'(pair_valid), 32'h0);
        chk("R5 single-cycle strobe", 32'(dbl), 32'h0);

        summary();
        $finish;
    end
endmodule